// File: doc/BRIEF.md
# MDIO Management Master

This block acts as the station-management master on a two-wire PHY management bus and uses clause-22 frames. A host sets up a transaction through one 32-bit command register. The command holds the direction, the PHY address, the register address and, for a write, the 16-bit data. The transaction starts when the host sets the start flag in the same register.

The block divides the system clock down to make the management clock. It shifts the frame out on a split bidirectional data line made of an output value, an output enable and an input. On a read, it stores the returned data and the PHY's acknowledge in the register. When the frame is done, the start flag clears itself. The host polls that flag to learn that the result is ready.

A global enable input decides whether new transactions can start. Dropping the enable does not cut a frame that is already on the wire.

Top module: `mdio_master`

## Requirements
- R1: After reset the register reads 0x0000_0000, `mdc_o` is low and `mdio_oe_o` is low. `mdio_oe_o` stays low whenever the start flag (bit 31) reads 0.
- R2: Writing 1 to bit 31 (start flag) sets it only while `en_i` is high. A write with bit 31 = 1 while `en_i` is low leaves the flag at 0 but still stores the other writable fields. Writing 0 to bit 31 never starts a transaction.
- R3: While bit 31 reads 1, every host write is discarded, so the whole register holds its value.
- R4: Bit 31 clears itself on the system clock edge that ends the last management-clock period of the frame. From then on `mdc_o` stays low until the next transaction.
- R5: When bit 30 = 1 the frame is a write. MSB first, it sends 32 ones, start 01, opcode 01, PHY address (bits 20:16), register address (bits 25:21), turnaround 10 and data bits 15:0. `mdio_oe_o` is high for all 64 bits.
- R6: When bit 30 = 0 the frame is a read. It uses the same header with opcode 10. `mdio_oe_o` goes low from the first turnaround bit (frame bit 46, counting from 0) to the end of the frame.
- R7: On a read, the 16 bits the PHY drives after turnaround are stored MSB first in bits 15:0. Bit 29 (acknowledge) is set if `mdio_i` is low at the second turnaround bit and cleared if it is high. Bit 29 is read-only to the host.
- R8: `mdc_o` toggles every `DIV_HALF` system clocks while a frame is active. `mdio_o` and `mdio_oe_o` change only while `mdc_o` is low, and `mdio_i` is sampled on the rising edge of `mdc_o`.
- R9: Bits 28:26 always read 0.
- R10: Dropping `en_i` in the middle of a frame does not stop it. The frame completes and its results are stored as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Engine enable; gates setting of the start flag |
| reg_wr_i | input | 1 | Host write strobe for the command register |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Command register read value |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data, output value |
| mdio_oe_o | output | 1 | Management data, output enable |
| mdio_i | input | 1 | Management data, sampled input |

## Verification
The checker watches several rules on every cycle:
- the reserved bits read zero;
- the register is frozen while the start flag is set;
- the bus is quiet and the clock is low whenever the flag is clear;
- the data line never moves while the management clock is high;
- the flag rises only after an enabled write of a one.

Frame content, read-data capture, the acknowledge outcome for both turnaround levels, the clock period, and completion after a mid-frame disable depend on a PHY answering across a whole frame. Only the bench's scenarios can show these, by acting as that PHY and comparing the bits it captures.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int ADDR_BITS  = 5;
  localparam int DAT_BITS   = 16;
  localparam int HDR_BITS   = 4 + 2 * ADDR_BITS;
  localparam int FRAME_BITS = PRE_BITS + HDR_BITS + 2 + DAT_BITS;
  localparam int RLS_IDX    = PRE_BITS + HDR_BITS;
  localparam int ACK_IDX    = RLS_IDX + 1;
  localparam int DAT_IDX    = RLS_IDX + 2;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic                 go;
    logic                 wr;
    logic                 ack;
    logic [ADDR_BITS-1:0] reg_a;
    logic [ADDR_BITS-1:0] phy_a;
    logic [DAT_BITS-1:0]  data;
  } cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(input cmd_t c);
    logic [1:0] op, ta;
    logic [DAT_BITS-1:0] d;
    op = c.wr ? 2'b01 : 2'b10;
    ta = c.wr ? 2'b10 : 2'b11;
    d  = c.wr ? c.data : '1;
    return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy_a, c.reg_a, ta, d};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = $clog2(DIV_HALF + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick   = run_i && (cnt_q == CNT_MAX);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  cmd_t                cmd_i,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                mdio_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                is_rd_o,
  output logic                ack_o,
  output logic [DAT_BITS-1:0] rdat_o,
  output logic                mdio_o,
  output logic                mdio_oe_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] RLS  = IDX_W'(RLS_IDX);
  localparam logic [IDX_W-1:0] AIX  = IDX_W'(ACK_IDX);
  localparam logic [IDX_W-1:0] DIX  = IDX_W'(DAT_IDX);

  logic                  busy_q, is_rd_q, ack_q;
  logic [IDX_W-1:0]      idx_q;
  logic [FRAME_BITS-1:0] sh_out_q;
  logic [DAT_BITS-1:0]   sh_in_q;

  assign done_o    = busy_q && fall_i && (idx_q == LAST);
  assign busy_o    = busy_q;
  assign is_rd_o   = is_rd_q;
  assign ack_o     = ack_q;
  assign rdat_o    = sh_in_q;
  assign mdio_o    = busy_q ? sh_out_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe_o = busy_q && (!is_rd_q || (idx_q < RLS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      is_rd_q  <= 1'b0;
      ack_q    <= 1'b0;
      idx_q    <= '0;
      sh_out_q <= '1;
      sh_in_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q   <= 1'b1;
        is_rd_q  <= !cmd_i.wr;
        idx_q    <= '0;
        sh_out_q <= build_frame(cmd_i);
      end
    end else begin
      // sample on rising MDC
      if (rise_i && is_rd_q) begin
        if (idx_q == AIX) ack_q <= !mdio_i;
        if (idx_q >= DIX) sh_in_q <= {sh_in_q[DAT_BITS-2:0], mdio_i};
      end
      // advance on falling MDC
      if (fall_i) begin
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
        end else begin
          idx_q    <= idx_q + 1'b1;
          sh_out_q <= {sh_out_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
  import mdio_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                wr_i,
  input  logic [31:0]         wdata_i,
  input  logic                done_i,
  input  logic                done_rd_i,
  input  logic                ack_i,
  input  logic [DAT_BITS-1:0] rdat_i,
  output cmd_t                cmd_o,
  output logic [31:0]         rdata_o
);
  cmd_t cmd_q;

  assign cmd_o   = cmd_q;
  assign rdata_o = {cmd_q.go, cmd_q.wr, cmd_q.ack, 3'b000,
                    cmd_q.reg_a, cmd_q.phy_a, cmd_q.data};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (cmd_q.go) begin
      if (done_i) begin
        cmd_q.go <= 1'b0;
        if (done_rd_i) begin
          cmd_q.data <= rdat_i;
          cmd_q.ack  <= ack_i;
        end
      end
    end else if (wr_i) begin
      cmd_q.go    <= wdata_i[31] && en_i;
      cmd_q.wr    <= wdata_i[30];
      cmd_q.reg_a <= wdata_i[25:21];
      cmd_q.phy_a <= wdata_i[20:16];
      cmd_q.data  <= wdata_i[15:0];
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        reg_wr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  cmd_t                cmd;
  logic                busy, done, is_rd, ack, rise, fall, start;
  logic [DAT_BITS-1:0] rdat;

  assign start = cmd.go && !busy;

  mdio_cmd_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .done_i    (done),
    .done_rd_i (is_rd),
    .ack_i     (ack),
    .rdat_i    (rdat),
    .cmd_o     (cmd),
    .rdata_o   (reg_rdata_o)
  );

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_engine u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .cmd_i     (cmd),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .is_rd_o   (is_rd),
    .ack_o     (ack),
    .rdat_o    (rdat),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        reg_wr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  // R9
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[28:26] == 3'b000);

  // R3
  reg_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[31] && $past(reg_rdata_o[31]) |-> $stable(reg_rdata_o));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[31] |-> !mdio_oe_o);

  // R4
  idle_mdc_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[31] |-> !mdc_o);

  // R8
  mdio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o && $past(mdc_o) |-> $stable(mdio_o) && $stable(mdio_oe_o));

  // R2
  go_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[31]) |-> $past(en_i) && $past(reg_wr_i) && $past(reg_wdata_i[31]));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .mdc_o       (mdc_o),
  .mdio_o      (mdio_o),
  .mdio_oe_o   (mdio_oe_o)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  localparam int DIV_HALF = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdo, moe;
  logic        mdi = 1'b1;
  int          total = 0;
  int          bad = 0;

  always #4 clk = ~clk;

  mdio_master #(.DIV_HALF(DIV_HALF)) u_mdio_master (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .reg_wr_i(reg_wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc),
    .mdio_o(mdo), .mdio_oe_o(moe), .mdio_i(mdi)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [31:0] v);
    @(negedge clk); reg_wr = 1'b1; wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  function automatic logic [31:0] cmd(input logic go, input logic w, input logic [4:0] ra,
                                      input logic [4:0] pa, input logic [15:0] d);
    return {go, w, 1'b0, 3'b000, ra, pa, d};
  endfunction

  // acts as the PHY for one frame
  task automatic phy(input logic ack_lo, input logic [15:0] rd,
                     output logic [63:0] bits, output logic [63:0] oes);
    for (int i = 0; i < 64; i++) begin
      @(posedge mdc); #1;
      bits[63-i] = mdo;
      oes[63-i]  = moe;
      if (i < 63) begin
        @(negedge mdc);
        if (i + 1 == 47)      mdi = !ack_lo;
        else if (i + 1 >= 48) mdi = rd[63-(i+1)];
        else                  mdi = 1'b1;
      end
    end
    mdi = 1'b1;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && rdata[31]; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reg", 64'(rdata), 64'h0);
    check("R1 mdc", 64'(mdc), 64'h0);
    check("R1 oe", 64'(moe), 64'h0);
  endtask

  task automatic t_write();
    logic [63:0] b, o;
    time t0, t1;
    en = 1'b1;
    host_wr(cmd(1'b1, 1'b1, 5'h0A, 5'h13, 16'hBEEF));
    check("R2 go set", 64'(rdata[31]), 64'h1);
    fork
      phy(1'b0, 16'h0, b, o);
      begin
        @(posedge mdc); t0 = $time;
        @(posedge mdc); t1 = $time;
      end
    join
    check("R8 mdc period", 64'(t1 - t0), 64'(2 * DIV_HALF * 8));
    check("R5 frame", b, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h13, 5'h0A, 2'b10, 16'hBEEF});
    check("R5 oe", o, '1);
    wait_idle();
    check("R4 go cleared", 64'(rdata[31]), 64'h0);
    repeat (3 * DIV_HALF) @(negedge clk);
    check("R4 mdc low", 64'(mdc), 64'h0);
    check("R9 rsvd", 64'(rdata[28:26]), 64'h0);
  endtask

  task automatic t_read(input logic ack_lo, input logic [15:0] v);
    logic [63:0] b, o;
    host_wr(cmd(1'b1, 1'b0, 5'h1F, 5'h01, 16'h1234));
    phy(ack_lo, v, b, o);
    check("R6 header", 64'(b[63:18]), 64'({32'hFFFF_FFFF, 2'b01, 2'b10, 5'h01, 5'h1F}));
    check("R6 oe", o, {{46{1'b1}}, 18'h0});
    wait_idle();
    check("R7 data", 64'(rdata[15:0]), 64'(v));
    check("R7 ack", 64'(rdata[29]), 64'(ack_lo));
  endtask

  task automatic t_locked();
    logic [63:0] b, o;
    logic [31:0] snap;
    host_wr(cmd(1'b1, 1'b1, 5'h02, 5'h03, 16'h0F0F));
    fork
      phy(1'b0, 16'h0, b, o);
      begin
        repeat (20) @(negedge clk);
        snap = rdata;
        host_wr(32'h4000_5555);
        check("R3 locked", 64'(rdata), 64'(snap));
      end
    join
    check("R3 frame intact", 64'(b[15:0]), 64'h0F0F);
    wait_idle();
    check("R3 after", 64'(rdata), 64'(cmd(1'b0, 1'b1, 5'h02, 5'h03, 16'h0F0F)) | 64'(rdata[29]) << 29);
  endtask

  task automatic t_enable();
    logic [63:0] b, o;
    host_wr(cmd(1'b1, 1'b0, 5'h04, 5'h05, 16'h0));
    fork
      phy(1'b1, 16'hA5C3, b, o);
      begin
        repeat (100) @(negedge clk);
        en = 1'b0;
      end
    join
    wait_idle();
    check("R10 completes", 64'(rdata[15:0]), 64'hA5C3);
    check("R10 go clear", 64'(rdata[31]), 64'h0);
    host_wr(cmd(1'b1, 1'b1, 5'h06, 5'h07, 16'h7777));
    check("R2 disabled go", 64'(rdata[31]), 64'h0);
    check("R2 fields kept", 64'(rdata[30:0] & 32'h43FF_FFFF), 64'(cmd(1'b0, 1'b1, 5'h06, 5'h07, 16'h7777)));
    repeat (4 * DIV_HALF) @(negedge clk);
    check("R2 no frame", 64'({mdc, moe}), 64'h0);
    en = 1'b1;
    host_wr(cmd(1'b0, 1'b1, 5'h06, 5'h07, 16'h7777));
    repeat (4 * DIV_HALF) @(negedge clk);
    check("R2 write zero", 64'({rdata[31], mdc}), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write();
    t_read(1'b1, 16'hC0DE);
    t_read(1'b0, 16'h8001);
    t_locked();
    t_enable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule